// File: doc/BRIEF.md
# Real-Mode Interrupt Vector Fetcher

This block resolves an 8-bit interrupt vector number to its handler entry point. The handler table is flat and starts at physical address zero. It holds 256 slots of four bytes each. Each slot holds a 16-bit offset word and then a 16-bit segment word.

A start strobe latches the vector. The block then reads the offset word and the segment word, in that order, through a synchronous read port that uses a request/valid handshake. It shifts the segment left by four bits, adds the offset, and keeps the 20-bit result. It presents the offset, the segment and the linear handler address, and raises a one-cycle done pulse.

The slot is found by direct indexing, so every vector takes the same number of cycles for a given memory latency. The block has no search step and no data-dependent path.

Top module: `vec_fetch`

## Requirements
- R1: For vector N, the first read goes to byte address N*4 and returns the offset. The second read goes to N*4+2 and returns the segment. Every request address lies in 0x00000..0x003FF.
- R2: mem_req_o stays high with mem_addr_o unchanged until mem_valid_i is high. Read data is taken only in a cycle where mem_req_o and mem_valid_i are both high.
- R3: handler_addr_o equals (segment_o * 16 + offset_o) modulo 2^20, so a carry out of bit 19 is dropped.
- R4: Let L be the number of cycles each read waits for valid. done_o is high after the (3 + 2*L)-th rising edge, counting the edge that samples start_i as the first. This count is the same for every vector.
- R5: done_o is high for exactly one cycle per fetch. offset_o, segment_o and handler_addr_o keep their values after done until a later fetch loads new words.
- R6: busy_o is high from the cycle after start_i is accepted through the done cycle, and low otherwise. mem_req_o is high only while busy_o is high.
- R7: A start_i pulse while busy_o is high is ignored. The fetch in progress keeps its vector and its addresses, and no extra fetch follows.
- R8: While rst_ni is low, busy_o, done_o and mem_req_o are low and offset_o, segment_o and handler_addr_o are zero. This holds even if reset arrives in the middle of a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a lookup of vector_i (accepted when idle) |
| vector_i | input | 8 | Interrupt vector number |
| mem_req_o | output | 1 | Read request to the table memory |
| mem_addr_o | output | 20 | Byte address of the requested word |
| mem_valid_i | input | 1 | Read data valid for the current request |
| mem_rdata_i | input | 16 | Read data word |
| busy_o | output | 1 | Lookup in progress |
| done_o | output | 1 | One-cycle completion pulse |
| offset_o | output | 16 | Handler offset word |
| segment_o | output | 16 | Handler segment word |
| handler_addr_o | output | 20 | Linear handler address |

## Verification
Two cases are hard to reach from the ports. The first is a start strobe arriving while a read is still waiting for valid. The bench drives a second start with a different vector during the offset read, then confirms that the two accepted addresses still belong to the first vector and that only one done pulse appears. The second is a carry out of bit 19. Table words pinned to 0xFFFF/0xFFFF and to segment 0xFFFF/offset 0x0010 produce a wrapped sum, and a sweep of all 256 vectors with latencies of 0 to 2 cycles covers the ordinary cases.

// File: rtl/ivf_pkg.sv
package ivf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_OFF = 2'd1,
    ST_RD_SEG = 2'd2,
    ST_DONE   = 2'd3
  } ivf_state_e;
endpackage

// File: rtl/ivf_seq.sv
module ivf_seq
  import ivf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mem_valid_i,
  output logic req_o,
  output logic seg_phase_o,
  output logic busy_o,
  output logic done_o,
  output logic load_o,
  output logic take_off_o,
  output logic take_seg_o
);
  ivf_state_e st_q, st_d;
  logic ack;

  assign ack = req_o && mem_valid_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = ST_RD_OFF;
      ST_RD_OFF: if (ack)     st_d = ST_RD_SEG;
      ST_RD_SEG: if (ack)     st_d = ST_DONE;
      ST_DONE:                st_d = ST_IDLE;
      default:                st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign req_o       = (st_q == ST_RD_OFF) || (st_q == ST_RD_SEG);
  assign seg_phase_o = (st_q == ST_RD_SEG);
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign load_o      = (st_q == ST_IDLE) && start_i;
  assign take_off_o  = (st_q == ST_RD_OFF) && ack;
  assign take_seg_o  = (st_q == ST_RD_SEG) && ack;

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_start_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && req_o && !seg_phase_o));

  // a start during a fetch must not restart the offset read
  p_start_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_phase_o && start_i && !mem_valid_i) |=> seg_phase_o);

  p_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !seg_phase_o && mem_valid_i) |=> (req_o && seg_phase_o));
endmodule

// File: rtl/ivf_addr_gen.sv
module ivf_addr_gen #(
  parameter int VEC_W       = 8,
  parameter int ADDR_W      = 20,
  parameter int ENTRY_BYTES = 4,
  parameter int WORD_BYTES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [VEC_W-1:0]  vector_i,
  input  logic              seg_phase_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [VEC_W-1:0]  vec_q;
  logic [ADDR_W-1:0] base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vec_q <= '0;
    else if (load_i) vec_q <= vector_i;
  end

  assign base   = ADDR_W'(vec_q) * ADDR_W'(ENTRY_BYTES);
  assign addr_o = base + (seg_phase_i ? ADDR_W'(WORD_BYTES) : '0);
endmodule

// File: rtl/ivf_linear.sv
module ivf_linear #(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic [WORD_W-1:0] segment_i,
  input  logic [WORD_W-1:0] offset_i,
  output logic [ADDR_W-1:0] linear_o
);
  logic [ADDR_W-1:0] seg_ext, off_ext;

  // the carry out of the top bit falls off the ADDR_W-wide sum
  assign seg_ext  = ADDR_W'(segment_i) << SEG_SHIFT;
  assign off_ext  = ADDR_W'(offset_i);
  assign linear_o = seg_ext + off_ext;
endmodule

// File: rtl/vec_fetch.sv
module vec_fetch #(
  parameter int VEC_W       = 8,
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 20,
  parameter int ENTRY_BYTES = 4,
  parameter int SEG_SHIFT   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VEC_W-1:0]  vector_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] offset_o,
  output logic [WORD_W-1:0] segment_o,
  output logic [ADDR_W-1:0] handler_addr_o
);
  localparam int WORD_BYTES  = WORD_W / 8;
  localparam int TABLE_BYTES = (1 << VEC_W) * ENTRY_BYTES;

  logic seg_phase, load, take_off, take_seg;
  logic [WORD_W-1:0] off_q, seg_q;

  ivf_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mem_valid_i (mem_valid_i),
    .req_o       (mem_req_o),
    .seg_phase_o (seg_phase),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .load_o      (load),
    .take_off_o  (take_off),
    .take_seg_o  (take_seg)
  );

  ivf_addr_gen #(
    .VEC_W       (VEC_W),
    .ADDR_W      (ADDR_W),
    .ENTRY_BYTES (ENTRY_BYTES),
    .WORD_BYTES  (WORD_BYTES)
  ) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .vector_i    (vector_i),
    .seg_phase_i (seg_phase),
    .addr_o      (mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      seg_q <= '0;
    end else begin
      if (take_off) off_q <= mem_rdata_i;
      if (take_seg) seg_q <= mem_rdata_i;
    end
  end

  ivf_linear #(
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .SEG_SHIFT (SEG_SHIFT)
  ) u_lin (
    .segment_i (seg_q),
    .offset_i  (off_q),
    .linear_o  (handler_addr_o)
  );

  assign offset_o  = off_q;
  assign segment_o = seg_q;

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_in_table_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (32'(mem_addr_o) < TABLE_BYTES));

  p_hold_out_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && mem_valid_i) |=> ($stable(offset_o) && $stable(segment_o)
                                     && $stable(handler_addr_o)));

  p_req_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  p_done_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_o && !mem_req_o));
endmodule

// File: tb/test_vec_fetch.sv
module test_vec_fetch;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  vector_i = '0;
  logic        mem_req_o, mem_valid_i, busy_o, done_o;
  logic [19:0] mem_addr_o, handler_addr_o;
  logic [15:0] mem_rdata_i, offset_o, segment_o;

  int checks = 0;
  int failures = 0;

  logic [1:0]  lat = '0;
  logic [1:0]  wait_cnt = '0;
  logic        ovr_en = 1'b0;
  logic [15:0] ovr_off = '0, ovr_seg = '0;
  logic [19:0] seen_addr [0:1023];
  int          seen_n = 0;

  always #10 clk = ~clk;

  vec_fetch i_vec_fetch (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .vector_i       (vector_i),
    .mem_req_o      (mem_req_o),
    .mem_addr_o     (mem_addr_o),
    .mem_valid_i    (mem_valid_i),
    .mem_rdata_i    (mem_rdata_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .offset_o       (offset_o),
    .segment_o      (segment_o),
    .handler_addr_o (handler_addr_o)
  );

  function automatic logic [15:0] word_of(input logic [19:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'd40503;
    return t[15:0] ^ 16'hC3A5 ^ {a[5:2], 12'h000};
  endfunction

  function automatic logic [15:0] table_word(input logic [19:0] a);
    if (ovr_en) return a[1] ? ovr_seg : ovr_off;
    return word_of(a);
  endfunction

  assign mem_valid_i = mem_req_o && (wait_cnt == lat);
  assign mem_rdata_i = table_word(mem_addr_o);

  always @(posedge clk) begin
    if (mem_req_o && mem_valid_i) begin
      wait_cnt <= '0;
      if (seen_n < 1024) seen_addr[seen_n] = mem_addr_o;
      seen_n = seen_n + 1;
    end else if (mem_req_o) begin
      wait_cnt <= wait_cnt + 2'd1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [7:0] v, input logic [1:0] l, input bit inject);
    int base, cycles, exp_cyc;
    logic [15:0] eo, es;
    logic [20:0] sum;
    logic [19:0] eh;
    @(negedge clk);
    lat = l;
    base = seen_n;
    start_i = 1'b1;
    vector_i = v;
    @(negedge clk);
    start_i = 1'b0;
    cycles = 1;
    check(busy_o == 1'b1, "R6 busy after start", 32'(busy_o), 1);
    if (inject) begin
      start_i = 1'b1;
      vector_i = ~v;
    end
    while (!done_o && cycles < 40) begin
      @(negedge clk);
      start_i = 1'b0;
      cycles++;
      if (!done_o && !busy_o) check(1'b0, "R6 busy dropped early", 0, 1);
    end
    exp_cyc = 3 + 2 * int'(l);
    check(cycles == exp_cyc, "R4 done latency", 32'(cycles), 32'(exp_cyc));
    eo = table_word(20'(v) * 20'd4);
    es = table_word(20'(v) * 20'd4 + 20'd2);
    sum = ({5'b0, es} << 4) + {5'b0, eo};
    eh = sum[19:0];
    check(seen_n - base == 2, "R7 exactly two reads", 32'(seen_n - base), 2);
    check(seen_addr[base] == 20'(v) * 20'd4, "R1 offset address",
          32'(seen_addr[base]), 32'(v) * 4);
    check(seen_addr[base+1] == 20'(v) * 20'd4 + 20'd2, "R1 segment address",
          32'(seen_addr[base+1]), 32'(v) * 4 + 2);
    check(offset_o == eo, "R2 offset word", 32'(offset_o), 32'(eo));
    check(segment_o == es, "R2 segment word", 32'(segment_o), 32'(es));
    check(handler_addr_o == eh, "R3 linear address", 32'(handler_addr_o), 32'(eh));
    @(negedge clk);
    check(done_o == 1'b0, "R5 done one cycle", 32'(done_o), 0);
    check(busy_o == 1'b0, "R6 busy low after done", 32'(busy_o), 0);
    @(negedge clk);
    check(handler_addr_o == eh && offset_o == eo && segment_o == es,
          "R5 outputs held", 32'(handler_addr_o), 32'(eh));
    check(seen_n - base == 2 && !busy_o, "R7 no extra fetch",
          32'(seen_n - base), 2);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !mem_req_o, "R8 reset control",
          {29'b0, busy_o, done_o, mem_req_o}, 0);
    check(offset_o == 0 && segment_o == 0 && handler_addr_o == 0,
          "R8 reset outputs", 32'(handler_addr_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // directed: vector 9, carry wrap, wrap to exactly zero
    ovr_en = 1'b1;
    ovr_off = 16'h1234; ovr_seg = 16'hABCD;
    fetch(8'd9, 2'd0, 1'b0);
    check(handler_addr_o == 20'hACF04, "R3 vector 9 sum", 32'(handler_addr_o), 32'hACF04);
    ovr_off = 16'hFFFF; ovr_seg = 16'hFFFF;
    fetch(8'd255, 2'd1, 1'b1);
    check(handler_addr_o == 20'h0FFEF, "R3 carry dropped", 32'(handler_addr_o), 32'h0FFEF);
    ovr_off = 16'h0010; ovr_seg = 16'hFFFF;
    fetch(8'd64, 2'd2, 1'b0);
    check(handler_addr_o == 20'h00000, "R3 wrap to zero", 32'(handler_addr_o), 0);
    ovr_en = 1'b0;

    for (int v = 0; v < 256; v++)
      fetch(8'(v), 2'(v % 3), (v % 17) == 5);

    // reset in the middle of a fetch
    @(negedge clk);
    lat = 2'd2;
    start_i = 1'b1;
    vector_i = 8'd77;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(!busy_o && !done_o && !mem_req_o, "R8 mid-fetch reset",
          {29'b0, busy_o, done_o, mem_req_o}, 0);
    check(offset_o == 0 && segment_o == 0 && handler_addr_o == 0,
          "R8 mid-fetch outputs", 32'(handler_addr_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!busy_o && !mem_req_o, "R8 idle after reset", 32'(busy_o), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule